// File: doc/BRIEF.md
# Voice Interrupt Pending Stack

A wavetable engine has many voices. Each voice may raise an interrupt when it reaches the end of its sample or the end of a volume ramp. This block collects those requests and hands them to a host one at a time. A voice pushes an entry that holds its 5-bit number and two cause flags, one for wave and one for ramp. Each host read of the voice status register pops one entry and returns an encoded status byte.

The storage is a stack, so the most recent request is served first. Two summary flags always show the causes of the entry now on top of the stack. A pending output is high while any entry is stored. Requests that arrive while the stack is full are lost. A push and a pop in the same cycle pass the new entry straight to the host.

Top module: `voice_irq_stack`

## Requirements
- R1: While reset is asserted and right after it, the stack is empty, `irq_pending_o`, `agg_wave_o` and `agg_ramp_o` are 0, and `status_o` reads 0xE0.
- R2: Popped entries come out in reverse order of the pushes that stored them (last in, first out).
- R3: A pop loads `status_o` on the same clock edge, and the value holds until the next pop. The byte is laid out as follows: bit 7 = NOT wave, bit 6 = NOT ramp, bit 5 = 1, bits 4:0 = voice number.
- R4: A pop from an empty stack with no push in that cycle returns 0xE0 and leaves the stack and flags as they were.
- R5: A push without a pop while the stack holds DEPTH entries is dropped. The stored entries and the depth are unchanged.
- R6: A push that is stored sets `agg_wave_o` and `agg_ramp_o` to the flags of the pushed entry on the next edge.
- R7: After a pop, `agg_wave_o` and `agg_ramp_o` show the flags of the new top entry, or 0 when the stack is now empty.
- R8: A push and a pop in the same cycle return the pushed entry in `status_o` and leave the depth, the stored entries and the summary flags unchanged. This also holds when the stack is empty.
- R9: `irq_pending_o` is high exactly when the stack holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; empties the stack |
| push_i | input | 1 | A voice requests an interrupt this cycle |
| push_voice_i | input | 5 | Number of the requesting voice |
| push_wave_i | input | 1 | The request is an end-of-sample cause |
| push_ramp_i | input | 1 | The request is an end-of-ramp cause |
| pop_i | input | 1 | Host read of the voice status register |
| status_o | output | 8 | Encoded status of the last popped entry |
| agg_wave_o | output | 1 | Wave flag of the current top entry |
| agg_ramp_o | output | 1 | Ramp flag of the current top entry |
| irq_pending_o | output | 1 | The stack is not empty |

## Verification
The bench builds the block with DEPTH = 4, so the full condition is reached after four pushes. This lets the dropped fifth push, the pop that empties a full stack, and the pass-through at both an empty and a partly filled stack all happen in a few dozen cycles. The default depth of 1024 differs only in counter width. The short run exercises the same full and empty boundaries that the large default has.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam int unsigned VOICE_W  = 5;
  localparam int unsigned STATUS_W = VOICE_W + 3;

  typedef struct packed {
    logic               wave;
    logic               ramp;
    logic [VOICE_W-1:0] voice;
  } irq_entry_t;

  localparam logic [STATUS_W-1:0] STATUS_IDLE = {3'b111, {VOICE_W{1'b0}}};
endpackage

// File: rtl/voice_irq_stack_ptr.sv
module voice_irq_stack_ptr #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_o,
  output logic          rd_o,
  output logic          bypass_o,
  output logic          has_next_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] wr_idx_o,
  output logic [AW-1:0] top_idx_o,
  output logic [AW-1:0] nxt_idx_o
);
  logic [CW-1:0] cnt_q, cnt_d, top_c, nxt_c;
  logic full, empty;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign bypass_o = push_i & pop_i;
  assign wr_o     = push_i & ~pop_i & ~full;
  assign rd_o     = pop_i & ~push_i & ~empty;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_o)      cnt_d = cnt_q + CW'(1);
    else if (rd_o) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign top_c      = cnt_q - CW'(1);
  assign nxt_c      = cnt_q - CW'(2);
  assign wr_idx_o   = cnt_q[AW-1:0];
  assign top_idx_o  = top_c[AW-1:0];
  assign nxt_idx_o  = nxt_c[AW-1:0];
  assign has_next_o = (cnt_q >= CW'(2));
  assign cnt_o      = cnt_q;

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_drop_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full) |=> (cnt_q == CW'(DEPTH)));
  assert_depth_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/voice_irq_stack_mem.sv
module voice_irq_stack_mem
  import voice_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       wr_i,
  input  logic [AW-1:0] wr_idx_i,
  input  irq_entry_t wr_data_i,
  input  logic [AW-1:0] top_idx_i,
  input  logic [AW-1:0] nxt_idx_i,
  output irq_entry_t top_o,
  output irq_entry_t nxt_o
);
  irq_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign top_o = mem_q[top_idx_i];
  assign nxt_o = mem_q[nxt_idx_i];
endmodule

// File: rtl/voice_irq_status_enc.sv
module voice_irq_status_enc
  import voice_irq_pkg::*;
(
  input  irq_entry_t          ent_i,
  output logic [STATUS_W-1:0] status_o
);
  // causes are reported active low, bit 5 is a fixed marker
  assign status_o = {~ent_i.wave, ~ent_i.ramp, 1'b1, ent_i.voice};
endmodule

// File: rtl/voice_irq_stack.sv
module voice_irq_stack
  import voice_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [VOICE_W-1:0] push_voice_i,
  input  logic               push_wave_i,
  input  logic               push_ramp_i,
  input  logic               pop_i,
  output logic [STATUS_W-1:0] status_o,
  output logic               agg_wave_o,
  output logic               agg_ramp_o,
  output logic               irq_pending_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = $clog2(DEPTH);

  irq_entry_t push_ent, top_ent, nxt_ent, pop_ent;
  logic wr, rd, bypass, has_next;
  logic [CW-1:0] cnt;
  logic [AW-1:0] wr_idx, top_idx, nxt_idx;
  logic [STATUS_W-1:0] pop_byte, status_q;
  logic wave_q, ramp_q;

  assign push_ent = '{wave: push_wave_i, ramp: push_ramp_i, voice: push_voice_i};

  voice_irq_stack_ptr #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) ptr_i (
    .clk_i, .rst_ni, .push_i, .pop_i,
    .wr_o(wr), .rd_o(rd), .bypass_o(bypass), .has_next_o(has_next),
    .cnt_o(cnt), .wr_idx_o(wr_idx), .top_idx_o(top_idx), .nxt_idx_o(nxt_idx)
  );

  voice_irq_stack_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk_i, .wr_i(wr), .wr_idx_i(wr_idx), .wr_data_i(push_ent),
    .top_idx_i(top_idx), .nxt_idx_i(nxt_idx), .top_o(top_ent), .nxt_o(nxt_ent)
  );

  always_comb begin
    pop_ent = '0;
    if (bypass)  pop_ent = push_ent;
    else if (rd) pop_ent = top_ent;
  end

  voice_irq_status_enc enc_i (.ent_i(pop_ent), .status_o(pop_byte));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_IDLE;
      wave_q   <= 1'b0;
      ramp_q   <= 1'b0;
    end else begin
      if (pop_i) status_q <= pop_byte;
      if (wr) begin
        wave_q <= push_wave_i;
        ramp_q <= push_ramp_i;
      end else if (rd) begin
        wave_q <= has_next & nxt_ent.wave;
        ramp_q <= has_next & nxt_ent.ramp;
      end
    end
  end

  assign status_o      = status_q;
  assign agg_wave_o    = wave_q;
  assign agg_ramp_o    = ramp_q;
  assign irq_pending_o = (cnt != '0);

  assert_marker_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[VOICE_W]);
  assert_idle_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !irq_pending_o) |=> (status_o == STATUS_IDLE));
  assert_flags_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_pending_o |-> (!agg_wave_o && !agg_ramp_o));
  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> (status_o == {~$past(push_wave_i), ~$past(push_ramp_i),
                                        1'b1, $past(push_voice_i)}));
  assert_flags_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> ($stable(agg_wave_o) && $stable(agg_ramp_o)));
endmodule

// File: tb/voice_irq_stack_tb_top.sv
module voice_irq_stack_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, wave = 1'b0, ramp = 1'b0, pop = 1'b0;
  logic [4:0] voice = '0;
  logic [7:0] status;
  logic agg_w, agg_r, pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int q[$];
  int exp_status = 8'hE0;
  bit exp_w = 1'b0, exp_r = 1'b0;

  always #10 clk = ~clk;

  voice_irq_stack #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_voice_i(voice),
    .push_wave_i(wave), .push_ramp_i(ramp), .pop_i(pop),
    .status_o(status), .agg_wave_o(agg_w), .agg_ramp_o(agg_r), .irq_pending_o(pend)
  );

  function automatic int enc(input int e);
    // e = {wave, ramp, voice[4:0]}
    return ((((e >> 6) & 1) ^ 1) << 7) | ((((e >> 5) & 1) ^ 1) << 6) | 32 | (e & 31);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "status", int'(status), exp_status);
    chk(tag, "agg_wave", int'(agg_w), int'(exp_w));
    chk(tag, "agg_ramp", int'(agg_r), int'(exp_r));
    chk({tag, "/R9"}, "pending", int'(pend), int'(q.size() > 0));
  endtask

  task automatic step(input bit p, input int v, input bit w, input bit r, input bit o,
                      input string tag);
    int e;
    push = p; voice = 5'(v); wave = w; ramp = r; pop = o;
    e = (int'(w) << 6) | (int'(r) << 5) | (v & 31);
    @(posedge clk);
    if (p && o) begin
      exp_status = enc(e);
    end else if (o) begin
      if (q.size() > 0) begin
        exp_status = enc(q.pop_back());
        if (q.size() > 0) begin
          exp_w = bit'((q[$] >> 6) & 1);
          exp_r = bit'((q[$] >> 5) & 1);
        end else begin
          exp_w = 1'b0; exp_r = 1'b0;
        end
      end else begin
        exp_status = 8'hE0;
      end
    end else if (p) begin
      if (q.size() < DEPTH) begin
        q.push_back(e);
        exp_w = w; exp_r = r;
      end
    end
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R6 pushes, R2 / R3 / R7 pops in reverse order
    step(1, 3, 1, 0, 0, "R6");
    step(1, 17, 0, 1, 0, "R6");
    step(1, 31, 1, 1, 0, "R6");
    step(0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, "R2");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    // R4 empty pop
    step(0, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 0, "R4");

    // R5 fill, drop the fifth push, then drain
    for (int i = 0; i < DEPTH; i++) step(1, i + 8, bit'(i & 1), bit'((i >> 1) & 1), 0, "R5");
    step(1, 30, 1, 1, 0, "R5");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, "R5");
    step(0, 0, 0, 0, 1, "R4");

    // R8 same-cycle push and pop
    step(1, 5, 0, 1, 0, "R8");
    step(1, 6, 1, 0, 0, "R8");
    step(1, 9, 1, 1, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(1, 12, 1, 0, 1, "R8");
    step(0, 0, 0, 0, 1, "R4");
    step(1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, "R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule